// File: doc/BRIEF.md
# Shared-Pointer Byte Ring Serial Port

This block sits between a host register bus and a pair of byte streams. It keeps two 32-byte ring buffers, one for outgoing and one for incoming bytes, and lets the host see both rings and their pointers as plain byte-wide locations. Each ring has two pointers. The hardware owns one of them and the host owns the other, so neither side ever has to wait for the other's bookkeeping.

For sending, the host places bytes into the transmit ring and then moves the transmit tail past them. The block offers the byte at the transmit head on its output stream and steps the head forward each time the sink accepts it. For receiving, the block writes each byte from its input stream at the receive tail and steps the tail. The host reads those bytes and releases them by moving the receive head. A ring is empty when its head equals its tail. A ring counts as full at 31 bytes, because one slot always stays free so that a full ring can be told apart from an empty one. Every pointer is read or written as one byte in a single bus access. The host bus is combinational on reads and takes writes at the clock edge.

Top module: `ringport`

## Requirements
- R1: While reset is held low at a clock edge, all four pointers and both rings go to zero. After reset, tx_valid is low, rx_ready is high and addresses 64 to 67 read zero.
- R2: A host write to an address from 0 to 31 stores the byte in transmit-ring slot addr[4:0]. A host read of 0 to 31 returns zero.
- R3: A write to address 65 sets the transmit tail to wdata[4:0], and reading 65 returns it. Reading 64 returns the transmit head, and a host write to 64 has no effect.
- R4: tx_valid is high exactly when the transmit head differs from the transmit tail. While it is high, tx_data is the transmit-ring byte at the head.
- R5: Each clock edge with tx_valid and tx_ready both high moves the transmit head forward by one, modulo 32. On any other edge the head keeps its value.
- R6: Each clock edge with rx_valid and rx_ready both high stores rx_data at the receive tail and moves the tail forward by one, modulo 32. The stored byte reads back at address 32 plus its slot, and reading 67 returns the tail.
- R7: rx_ready is low exactly when the receive tail plus one equals the receive head, modulo 32, which means 31 bytes are held. While it is low, no byte is stored and the tail holds.
- R8: A write to address 66 sets the receive head to wdata[4:0], and reading 66 returns it. A host write to 67 has no effect on the receive tail.
- R9: Host writes to addresses 32 to 63 leave the receive ring unchanged.
- R10: Addresses 68 to 127 read zero, and writes to them change nothing.
- R11: While host_sel is low, host_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receive ring has room |
| rx_data | input | 8 | Incoming byte |

## Verification
The assertions make no assumption about the stream inputs or the pointer values the host writes. A pointer may be moved anywhere in one write, and the checks on head and tail movement hold regardless. They do rely on the transmit head and the receive tail changing only through the stream handshakes, since the bus has no path to either. The stimulus usually moves the host-owned pointers a few slots ahead of where they are, and it puts random junk in the upper data bits. This drives both rings through the empty, partly filled, wrapped and full states rather than leaving them scattered at random.

// File: rtl/ringport_pkg.sv
// Package: shared types for the ring-buffer serial port.
// Assumes: nothing beyond the standard language.
package ringport_pkg;

    // Coarse host address region, taken from the two bits above the slot offset
    typedef enum logic [1:0] {
        RG_TXBUF = 2'd0,
        RG_RXBUF = 2'd1,
        RG_PTR   = 2'd2,
        RG_NONE  = 2'd3
    } ringport_region_e;

    // Pointer register select. The order fixes the addresses 64..67.
    typedef enum logic [1:0] {
        PS_TX_HEAD = 2'd0,
        PS_TX_TAIL = 2'd1,
        PS_RX_HEAD = 2'd2,
        PS_RX_TAIL = 2'd3
    } ringport_ptrsel_e;

endpackage

// File: rtl/ringport_ram.sv
// Module: ringport_ram
// What: one ring's storage. One synchronous write port, one combinational read port.
// Assumes: the reset clears every slot, so that reads never return undefined data.
module ringport_ram #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slot_q [DEPTH];

    // Purpose: clear on reset, otherwise store the written byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[widx] <= wdata;
        end
    end

    // Purpose: combinational read of the addressed slot
    always_comb rdata = slot_q[ridx];

endmodule

// File: rtl/ringport_tx_drain.sv
// Module: ringport_tx_drain
// What: owns the transmit head. Offers the byte at the head while the ring is
//       not empty, and steps the head on each accepted handshake.
// Assumes: the tail is owned and held stable by the host side.
module ringport_tx_drain #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  tail,
    input  logic [DATA_W-1:0] ring_byte,
    output logic [PTR_W-1:0]  head,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0] head_q;
    logic             fire;

    // Purpose: derive the offer and the handshake
    always_comb begin
        tx_valid = (head_q != tail);
        tx_data  = ring_byte;
        fire     = tx_valid && tx_ready;
        head     = head_q;
    end

    // Purpose: head register, which wraps naturally at the ring size
    always_ff @(posedge clk) begin
        if (!rst_n)    head_q <= '0;
        else if (fire) head_q <= head_q + STEP;
    end

endmodule

// File: rtl/ringport_rx_fill.sv
// Module: ringport_rx_fill
// What: owns the receive tail. Accepts stream bytes while one more would not
//       fill the last free slot, and hands each one to the ring storage.
// Assumes: the head is owned and held stable by the host side.
module ringport_rx_fill #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  head,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              ring_we,
    output logic [PTR_W-1:0]  ring_widx,
    output logic [DATA_W-1:0] ring_wdata,
    output logic [PTR_W-1:0]  tail
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] tail_nx;

    // Purpose: one-slot-free full test and the storage write request
    always_comb begin
        tail_nx    = tail_q + STEP;
        rx_ready   = (tail_nx != head);
        ring_we    = rx_valid && rx_ready;
        ring_widx  = tail_q;
        ring_wdata = rx_data;
        tail       = tail_q;
    end

    // Purpose: tail register, which advances on each stored byte
    always_ff @(posedge clk) begin
        if (!rst_n)       tail_q <= '0;
        else if (ring_we) tail_q <= tail_nx;
    end

endmodule

// File: rtl/ringport_hostdec.sv
// Module: ringport_hostdec
// What: decodes the host byte bus into transmit-ring writes, receive-ring reads
//       and the four pointer locations. Owns the transmit tail and the receive head.
// Assumes: PTR_W >= 2 and DATA_W >= PTR_W. Reads are combinational and writes
//       take effect at the clock edge.
module ringport_hostdec
    import ringport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [PTR_W+1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [PTR_W-1:0]  tx_head,
    input  logic [PTR_W-1:0]  rx_tail,
    input  logic [DATA_W-1:0] rx_ring_byte,
    output logic              tx_we,
    output logic [PTR_W-1:0]  tx_widx,
    output logic [DATA_W-1:0] tx_wdata,
    output logic [PTR_W-1:0]  rx_ridx,
    output logic [PTR_W-1:0]  tx_tail,
    output logic [PTR_W-1:0]  rx_head
);
    ringport_region_e region;
    ringport_ptrsel_e psel;
    logic             in_ptr;
    logic             do_wr;
    logic [PTR_W-1:0] tx_tail_q;
    logic [PTR_W-1:0] rx_head_q;

    // Purpose: split the address into region, pointer select and slot offset
    always_comb begin
        region  = ringport_region_e'(host_addr[PTR_W+1:PTR_W]);
        psel    = ringport_ptrsel_e'(host_addr[1:0]);
        in_ptr  = (region == RG_PTR) && (host_addr[PTR_W-1:2] == '0);
        do_wr   = host_sel && host_wr;
        tx_we   = do_wr && (region == RG_TXBUF);
        tx_widx = host_addr[PTR_W-1:0];
        tx_wdata = host_wdata;
        rx_ridx = host_addr[PTR_W-1:0];
        tx_tail = tx_tail_q;
        rx_head = rx_head_q;
    end

    // Purpose: host-owned pointers. Only the low PTR_W bits of a write count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tail_q <= '0;
            rx_head_q <= '0;
        end else if (do_wr && in_ptr) begin
            if (psel == PS_TX_TAIL) tx_tail_q <= host_wdata[PTR_W-1:0];
            if (psel == PS_RX_HEAD) rx_head_q <= host_wdata[PTR_W-1:0];
        end
    end

    // Purpose: read mux. Gives zero when idle, on writes, and on unreadable locations.
    always_comb begin
        host_rdata = '0;
        if (host_sel && !host_wr) begin
            unique case (region)
                RG_RXBUF: host_rdata = rx_ring_byte;
                RG_PTR: begin
                    if (in_ptr) begin
                        unique case (psel)
                            PS_TX_HEAD: host_rdata = DATA_W'(tx_head);
                            PS_TX_TAIL: host_rdata = DATA_W'(tx_tail_q);
                            PS_RX_HEAD: host_rdata = DATA_W'(rx_head_q);
                            PS_RX_TAIL: host_rdata = DATA_W'(rx_tail);
                        endcase
                    end
                end
                default: host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ringport.sv
// Module: ringport
// What: top of the shared-pointer ring serial port. Holds two rings, the host
//       decoder, the transmit drain engine and the receive fill engine.
// Assumes: synchronous active-low reset. Ring size is 2**PTR_W, and the host
//       address has PTR_W+2 bits.
module ringport #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [PTR_W+1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data
);
    logic [PTR_W-1:0]  tx_head, tx_tail, rx_head, rx_tail;
    logic              tx_we, rx_we;
    logic [PTR_W-1:0]  tx_widx, rx_widx, rx_ridx;
    logic [DATA_W-1:0] tx_wdata, rx_wdata, tx_ring_byte, rx_ring_byte;

    ringport_hostdec #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_hostdec (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_head(tx_head), .rx_tail(rx_tail), .rx_ring_byte(rx_ring_byte),
        .tx_we(tx_we), .tx_widx(tx_widx), .tx_wdata(tx_wdata),
        .rx_ridx(rx_ridx), .tx_tail(tx_tail), .rx_head(rx_head)
    );

    ringport_ram #(.DATA_W(DATA_W), .IDX_W(PTR_W)) u_tx_ram (
        .clk(clk), .rst_n(rst_n), .we(tx_we), .widx(tx_widx), .wdata(tx_wdata),
        .ridx(tx_head), .rdata(tx_ring_byte)
    );

    ringport_ram #(.DATA_W(DATA_W), .IDX_W(PTR_W)) u_rx_ram (
        .clk(clk), .rst_n(rst_n), .we(rx_we), .widx(rx_widx), .wdata(rx_wdata),
        .ridx(rx_ridx), .rdata(rx_ring_byte)
    );

    ringport_tx_drain #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_tx_drain (
        .clk(clk), .rst_n(rst_n), .tail(tx_tail), .ring_byte(tx_ring_byte),
        .head(tx_head), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    ringport_rx_fill #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rx_fill (
        .clk(clk), .rst_n(rst_n), .head(rx_head), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .ring_we(rx_we),
        .ring_widx(rx_widx), .ring_wdata(rx_wdata), .tail(rx_tail)
    );

endmodule

// File: rtl/ringport_chk.sv
// Module: ringport_chk
// What: temporal checks on pointer movement and the idle read bus. Bound into ringport.
// Assumes: the transmit head and the receive tail move only through handshakes.
module ringport_chk #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic [DATA_W-1:0] host_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [PTR_W-1:0]  tx_head,
    input logic [PTR_W-1:0]  rx_tail
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    // R5
    tx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_head == $past(tx_head) + STEP));

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_ready) |=> (tx_head == $past(tx_head)));

    // R6
    rx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (rx_tail == $past(rx_tail) + STEP));

    // R7
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> $stable(rx_tail));

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (host_rdata == '0));

endmodule

bind ringport ringport_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_head(tx_head), .rx_tail(rx_tail)
);

// File: tb/ringport_bench.sv
module ringport_bench;
    localparam int PW = 5;
    localparam int DW = 8;
    localparam int AW = PW + 2;
    localparam int N  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          tx_valid, rx_ready;
    logic          tx_ready = 1'b0, rx_valid = 1'b0;
    logic [DW-1:0] tx_data;
    logic [DW-1:0] rx_data = '0;

    always #4 clk = ~clk;

    ringport #(.DATA_W(DW), .PTR_W(PW)) u_ringport (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] m_tx [N];
    logic [DW-1:0] m_rx [N];
    logic [PW-1:0] m_txh = '0, m_txt = '0, m_rxh = '0, m_rxt = '0;

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        if (a < N)             return '0;
        else if (a < 2*N)      return m_rx[a - N];
        else if (a == 2*N)     return DW'(m_txh);
        else if (a == 2*N + 1) return DW'(m_txt);
        else if (a == 2*N + 2) return DW'(m_rxh);
        else if (a == 2*N + 3) return DW'(m_rxt);
        else                   return '0;
    endfunction

    function automatic string tag_for(logic [AW-1:0] a);
        if (a < N)                               return "R2";
        else if (a < 2*N)                        return "R6";
        else if (a == 2*N || a == 2*N + 1)       return "R3";
        else if (a == 2*N + 2 || a == 2*N + 3)   return "R8";
        else                                     return "R10";
    endfunction

    function automatic logic exp_rx_ready();
        logic [PW-1:0] nx;
        nx = m_rxt + PW'(1);
        return nx != m_rxh;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model to the next rising edge
    task automatic step(logic sel, logic wr, logic [AW-1:0] addr, logic [DW-1:0] wd,
                        logic txr, logic rxv, logic [DW-1:0] rxd, string rtag = "");
        logic tv, rr;
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd;
        tx_ready = txr; rx_valid = rxv; rx_data = rxd;
        #1;
        tv = (m_txh != m_txt);
        rr = exp_rx_ready();
        check("R4", "tx_valid", 32'(tx_valid), 32'(tv));
        if (tv) check("R4", "tx_data", 32'(tx_data), 32'(m_tx[m_txh]));
        check("R7", "rx_ready", 32'(rx_ready), 32'(rr));
        if (sel && !wr) check(rtag != "" ? rtag : tag_for(addr), "rdata", 32'(host_rdata), 32'(exp_read(addr)));
        if (!sel) check("R11", "idle rdata", 32'(host_rdata), 32'h0);
        if (tv && txr) m_txh = m_txh + PW'(1);
        if (rxv && rr) begin
            m_rx[m_rxt] = rxd;
            m_rxt = m_rxt + PW'(1);
        end
        if (sel && wr) begin
            if (addr < N)               m_tx[addr[PW-1:0]] = wd;
            else if (addr == 2*N + 1)   m_txt = wd[PW-1:0];
            else if (addr == 2*N + 2)   m_rxh = wd[PW-1:0];
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F3A_77C5));
        for (int i = 0; i < N; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: pointers zero after reset
        for (int a = 2*N; a < 2*N + 4; a++) step(1'b1, 1'b0, AW'(a), '0, 1'b0, 1'b0, '0, "R1");
        step(1'b1, 1'b0, AW'(N + 7), '0, 1'b0, 1'b0, '0, "R1");

        // R2: transmit ring is write-only to the host
        step(1'b1, 1'b1, AW'(0), 8'hA5, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, AW'(1), 8'h3C, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(0), '0, 1'b0, 1'b0, '0, "R2");

        // R3: tail write with junk upper bits, and head write ignored
        step(1'b1, 1'b1, AW'(2*N + 1), 8'hE2, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(2*N + 1), '0, 1'b0, 1'b0, '0, "R3");
        step(1'b1, 1'b1, AW'(2*N), 8'h07, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(2*N), '0, 1'b0, 1'b0, '0, "R3");

        // R4/R5: a stalled offer holds, then two bytes drain
        idle(3);
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, '0);
        step(1'b1, 1'b0, AW'(2*N), '0, 1'b1, 1'b0, '0, "R5");

        // R6/R7: fill the receive ring past capacity
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, DW'(8'h40 + i));
        step(1'b1, 1'b0, AW'(2*N + 3), '0, 1'b0, 1'b0, '0, "R6");
        step(1'b1, 1'b0, AW'(N + 5), '0, 1'b0, 1'b0, '0, "R6");
        step(1'b1, 1'b0, AW'(N + 30), '0, 1'b0, 1'b1, 8'hEE, "R7");

        // R8: free five slots, then the tail write is ignored
        step(1'b1, 1'b1, AW'(2*N + 2), 8'h25, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(2*N + 2), '0, 1'b0, 1'b0, '0, "R8");
        step(1'b1, 1'b1, AW'(2*N + 3), 8'h11, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(2*N + 3), '0, 1'b0, 1'b0, '0, "R8");

        // R9: host write into the receive ring is ignored
        step(1'b1, 1'b1, AW'(N + 1), 8'h99, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(N + 1), '0, 1'b0, 1'b0, '0, "R9");

        // R10: unmapped space
        step(1'b1, 1'b1, AW'(100), 8'h5A, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, AW'(100), '0, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b0, AW'(127), '0, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b0, AW'(2*N + 4), '0, 1'b0, 1'b0, '0, "R10");

        // Random mix. Pointer writes mostly move a few slots ahead.
        for (int i = 0; i < 6000; i++) begin
            logic          sel, wr, txr, rxv;
            logic [AW-1:0] a;
            logic [DW-1:0] wd;
            sel = ($urandom % 3) != 0;
            wr  = $urandom % 2;
            if (($urandom % 10) < 8) a = AW'($urandom % (2*N + 4));
            else                     a = AW'($urandom);
            wd = DW'($urandom);
            if (a == 2*N + 1) wd = {3'($urandom), 5'(m_txt + PW'($urandom % 5))};
            if (a == 2*N + 2) wd = {3'($urandom), 5'(m_rxh + PW'($urandom % 4))};
            txr = ($urandom % 4) != 0;
            rxv = ($urandom % 2) != 0;
            step(sel, wr, a, wd, txr, rxv, DW'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule